// File: doc/BRIEF.md
# Dual-Port RAM with Per-Port Shape Selection

This block is a true dual-port synchronous RAM holding 4608 bits. Each of its two ports has its own clock, a 12-bit address, 9-bit data in and out, an active-low enable, an active-low write strobe, and three configuration pins. The first pin is a 2-bit shape code that picks one of four depth-by-width arrangements. The second selects an extra output register. The third decides whether a write shows the written data on the output or leaves the last read value there.

The ports see one shared storage array. A word written through one shape can be read back through another: all shapes map onto the same rows, and narrow words sit at fixed bit positions within those rows. A shared active-low reset clears both output paths and blocks all accesses. It leaves the stored data untouched.

Top module: `shape_dpram`

## Requirements
- R1: The shape code selects the port geometry: 2'b00 is 4096 words of 1 bit, 2'b01 is 2048×2, 2'b10 is 1024×4 and 2'b11 is 512×9. The code is changed only while reset is held.
- R2: Address bits above the shape's depth are ignored. Bit [11] is ignored in the ×2 shape, bits [11:10] in the ×4 shape and bits [11:9] in the ×9 shape.
- R3: While a port's enable is high, that port neither reads nor writes, and its output keeps its value.
- R4: With the pipeline select low, a read (enable low, write strobe high) shows the addressed word on the output right after the clock edge that samples it.
- R5: With the pipeline select high, read data reaches the output one clock edge later than in R4. Back-to-back reads stream at one word per cycle.
- R6: During a write with the write-show bit low, the output keeps the data of the last read.
- R7: During a write with the write-show bit high, the output shows the written data, cut to the shape's width.
- R8: While reset is low, both outputs and all output registers go to zero on the port's clock edge and no write takes effect. The stored contents survive reset.
- R9: A ×9 word n occupies row n, bits 8:0. A narrow word n of width w occupies bits (w·n mod 8) up to (w·n mod 8)+w−1 of row (w·n)/8. Data written through one shape therefore reads back consistently through another.
- R10: When both ports write the same bit on a common clock edge, the value from port A is kept.
- R11: A read on one port in the same cycle as a write to that location from the other port returns the old contents.
- R12: Output bits above the shape's width read as zero, and data-in bits above the width are not stored.
- R13: Each port acts only on its own clock. A write presented on port B takes effect at B's edge, whatever port A's clock does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock |
| en_a_n | input | 1 | Port A enable, active low |
| we_a_n | input | 1 | Port A write strobe, low writes, high reads |
| shape_a | input | 2 | Port A shape code |
| pipe_a | input | 1 | Port A extra output register select |
| wshow_a | input | 1 | Port A show-written-data select |
| addr_a | input | 12 | Port A address |
| din_a | input | 9 | Port A write data |
| dout_a | output | 9 | Port A read data |
| clk_b | input | 1 | Port B clock |
| en_b_n | input | 1 | Port B enable, active low |
| we_b_n | input | 1 | Port B write strobe, low writes, high reads |
| shape_b | input | 2 | Port B shape code |
| pipe_b | input | 1 | Port B extra output register select |
| wshow_b | input | 1 | Port B show-written-data select |
| addr_b | input | 12 | Port B address |
| din_b | input | 9 | Port B write data |
| dout_b | output | 9 | Port B read data |
| rst_n | input | 1 | Shared synchronous reset, active low |

## Verification
The hardest situation to create from the ports is one where the ports' clocks really are separate, so that a write on B is held pending while A keeps running. The bench switches port B from the shared clock to a clock it toggles by hand. It presents a B write, lets A read the same word over several edges to show it unchanged, then gives B a single edge. The bench also needs same-cycle collisions and mixed shapes on the same rows. For these it drives both ports on one edge, and it changes shape codes under reset on purpose, relying on reset not to disturb the stored data.

// File: rtl/shape_dpram_pkg.sv
`timescale 1ns/1ps
// Package: shared geometry constants, the shape code type and the mask helper
// for the shape-selectable dual-port RAM. Assumes rows of 9 bits, of which the
// narrow shapes use the low 8.
package shape_dpram_pkg;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 9;
    localparam int ROWS    = 512;
    localparam int ROW_W   = $clog2(ROWS);
    localparam int COL_W   = 3;

    typedef enum logic [1:0] {
        SHP_X1 = 2'b00,
        SHP_X2 = 2'b01,
        SHP_X4 = 2'b10,
        SHP_X9 = 2'b11
    } shape_e;

    // Low-aligned mask of the data bits a shape uses.
    function automatic logic [DATA_W-1:0] shp_low_mask(input logic [1:0] s);
        case (s)
            SHP_X1:  return 9'h001;
            SHP_X2:  return 9'h003;
            SHP_X4:  return 9'h00F;
            default: return 9'h1FF;
        endcase
    endfunction
endpackage

// File: rtl/shape_dpram_decode.sv
`timescale 1ns/1ps
// Module: per-port shape decode. Turns a 12-bit address into a row index and
// a bit offset within the row, builds the aligned write mask and data, and
// extracts the addressed word from a read row. Purely combinational.
// Assumes narrow words never straddle rows (widths divide 8).
module shape_dpram_decode
    import shape_dpram_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int RW = ROW_W
) (
    input  logic [1:0]    shape,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    input  logic [DW-1:0] rd_row,
    output logic [RW-1:0] row,
    output logic [DW-1:0] wmask,
    output logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_word,
    output logic [DW-1:0] wr_word
);
    logic [COL_W-1:0] col;
    logic [DW-1:0]    low;

    // Row and column selection per shape; high address bits drop out here.
    always_comb begin
        case (shape)
            SHP_X1: begin row = addr[11:3]; col = addr[2:0];          end
            SHP_X2: begin row = addr[10:2]; col = {addr[1:0], 1'b0};  end
            SHP_X4: begin row = addr[9:1];  col = {addr[0], 2'b00};   end
            default: begin row = addr[8:0]; col = '0;                 end
        endcase
    end

    // Masks, aligned write data and extracted read word.
    always_comb begin
        low     = shp_low_mask(shape);
        wr_word = din & low;
        wmask   = low << col;
        wdata   = wr_word << col;
        rd_word = (rd_row >> col) & low;
    end
endmodule

// File: rtl/shape_dpram_core.sv
`timescale 1ns/1ps
// Module: storage core. Each port owns one bank it alone writes, plus one flag
// array; a bit's live copy is bank A when the two flags agree, bank B when not.
// This keeps every array single-clocked. Reads are combinational from the
// pre-edge contents. Assumes same-edge collision priority is only meaningful
// when both ports share a clock.
module shape_dpram_core
    import shape_dpram_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NR = ROWS,
    parameter int RW = ROW_W
) (
    input  logic          clk_a,
    input  logic          wr_a,
    input  logic [RW-1:0] row_a,
    input  logic [DW-1:0] mask_a,
    input  logic [DW-1:0] data_a,
    output logic [DW-1:0] rrow_a,
    input  logic          clk_b,
    input  logic          wr_b,
    input  logic [RW-1:0] row_b,
    input  logic [DW-1:0] mask_b,
    input  logic [DW-1:0] data_b,
    output logic [DW-1:0] rrow_b
);
    logic [DW-1:0] bank_a [NR];
    logic [DW-1:0] bank_b [NR];
    logic [DW-1:0] lvt_a  [NR];
    logic [DW-1:0] lvt_b  [NR];
    logic [DW-1:0] sel_a, sel_b, mask_b_eff;

    // Live-copy selection for both read rows.
    always_comb begin
        sel_a  = lvt_a[row_a] ^ lvt_b[row_a];
        sel_b  = lvt_a[row_b] ^ lvt_b[row_b];
        rrow_a = (bank_a[row_a] & ~sel_a) | (bank_b[row_a] & sel_a);
        rrow_b = (bank_a[row_b] & ~sel_b) | (bank_b[row_b] & sel_b);
    end

    // Port B yields any bit port A writes on the same row in this cycle.
    always_comb begin
        mask_b_eff = mask_b;
        if (wr_a && (row_a == row_b))
            mask_b_eff = mask_b & ~mask_a;
    end

    // Port A write: update its bank and mark the bits as A-owned.
    always_ff @(posedge clk_a) begin
        if (wr_a) begin
            bank_a[row_a] <= (bank_a[row_a] & ~mask_a) | (data_a & mask_a);
            lvt_a[row_a]  <= (lvt_a[row_a] & ~mask_a) | (lvt_b[row_a] & mask_a);
        end
    end

    // Port B write: update its bank and mark the bits as B-owned.
    always_ff @(posedge clk_b) begin
        if (wr_b) begin
            bank_b[row_b] <= (bank_b[row_b] & ~mask_b_eff) | (data_b & mask_b_eff);
            lvt_b[row_b]  <= (lvt_b[row_b] & ~mask_b_eff) | (~lvt_a[row_b] & mask_b_eff);
        end
    end
endmodule

// File: rtl/shape_dpram_outreg.sv
`timescale 1ns/1ps
// Module: per-port output path. A first register takes read data, or the
// written word when write-show is set, and holds otherwise. A second register
// follows it for the pipelined option. Both hold while the port is disabled
// and clear on the synchronous active-low reset.
module shape_dpram_outreg
    import shape_dpram_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_n,
    input  logic          we_n,
    input  logic          pipe,
    input  logic          wshow,
    input  logic [DW-1:0] rd_word,
    input  logic [DW-1:0] wr_word,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] stage1, stage2;

    // First stage: capture read data or written data, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage1 <= '0;
        else if (!en_n) begin
            if (we_n)
                stage1 <= rd_word;
            else if (wshow)
                stage1 <= wr_word;
        end
    end

    // Second stage: one-cycle delayed copy for pipelined reads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage2 <= '0;
        else if (!en_n)
            stage2 <= stage1;
    end

    assign dout = pipe ? stage2 : stage1;
endmodule

// File: rtl/shape_dpram.sv
`timescale 1ns/1ps
// Module: top of the shape-selectable dual-port RAM. Gathers both ports into
// arrays, builds one decode and one output path per port in a generate loop,
// and shares a single storage core. Assumes shape codes change only under
// reset and that reset is synchronous to each port's clock.
module shape_dpram
    import shape_dpram_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int NR = ROWS
) (
    input  logic          clk_a,
    input  logic          en_a_n,
    input  logic          we_a_n,
    input  logic [1:0]    shape_a,
    input  logic          pipe_a,
    input  logic          wshow_a,
    input  logic [AW-1:0] addr_a,
    input  logic [DW-1:0] din_a,
    output logic [DW-1:0] dout_a,
    input  logic          clk_b,
    input  logic          en_b_n,
    input  logic          we_b_n,
    input  logic [1:0]    shape_b,
    input  logic          pipe_b,
    input  logic          wshow_b,
    input  logic [AW-1:0] addr_b,
    input  logic [DW-1:0] din_b,
    output logic [DW-1:0] dout_b,
    input  logic          rst_n
);
    localparam int NP = 2;
    localparam int RW = $clog2(NR);

    logic [NP-1:0] p_clk, p_en_n, p_we_n, p_pipe, p_wshow, p_wr;
    logic [1:0]    p_shape [NP];
    logic [AW-1:0] p_addr  [NP];
    logic [DW-1:0] p_din   [NP];
    logic [DW-1:0] p_dout  [NP];
    logic [DW-1:0] p_wmask [NP];
    logic [DW-1:0] p_wdata [NP];
    logic [DW-1:0] p_rrow  [NP];
    logic [DW-1:0] p_rword [NP];
    logic [DW-1:0] p_wword [NP];
    logic [RW-1:0] p_row   [NP];

    // Port gathering: index 0 is port A, index 1 is port B.
    always_comb begin
        p_clk   = {clk_b, clk_a};
        p_en_n  = {en_b_n, en_a_n};
        p_we_n  = {we_b_n, we_a_n};
        p_pipe  = {pipe_b, pipe_a};
        p_wshow = {wshow_b, wshow_a};
        p_shape[0] = shape_a;  p_shape[1] = shape_b;
        p_addr[0]  = addr_a;   p_addr[1]  = addr_b;
        p_din[0]   = din_a;    p_din[1]   = din_b;
    end

    assign dout_a = p_dout[0];
    assign dout_b = p_dout[1];

    for (genvar g = 0; g < NP; g++) begin : g_port
        // Write qualifier: enabled, write strobe low, reset released.
        assign p_wr[g] = rst_n & ~p_en_n[g] & ~p_we_n[g];

        shape_dpram_decode #(.AW(AW), .DW(DW), .RW(RW)) u_dec (
            .shape   (p_shape[g]),
            .addr    (p_addr[g]),
            .din     (p_din[g]),
            .rd_row  (p_rrow[g]),
            .row     (p_row[g]),
            .wmask   (p_wmask[g]),
            .wdata   (p_wdata[g]),
            .rd_word (p_rword[g]),
            .wr_word (p_wword[g])
        );

        shape_dpram_outreg #(.DW(DW)) u_out (
            .clk     (p_clk[g]),
            .rst_n   (rst_n),
            .en_n    (p_en_n[g]),
            .we_n    (p_we_n[g]),
            .pipe    (p_pipe[g]),
            .wshow   (p_wshow[g]),
            .rd_word (p_rword[g]),
            .wr_word (p_wword[g]),
            .dout    (p_dout[g])
        );
    end

    shape_dpram_core #(.DW(DW), .NR(NR), .RW(RW)) u_core (
        .clk_a  (clk_a),
        .wr_a   (p_wr[0]),
        .row_a  (p_row[0]),
        .mask_a (p_wmask[0]),
        .data_a (p_wdata[0]),
        .rrow_a (p_rrow[0]),
        .clk_b  (clk_b),
        .wr_b   (p_wr[1]),
        .row_b  (p_row[1]),
        .mask_b (p_wmask[1]),
        .data_b (p_wdata[1]),
        .rrow_b (p_rrow[1])
    );
endmodule

// File: rtl/shape_dpram_chk.sv
`timescale 1ns/1ps
// Module: assertion checker for shape_dpram, attached by bind. Observes ports
// only. Assumes shape codes change only while reset is low.
module shape_dpram_chk
    import shape_dpram_pkg::*;
(
    input logic          clk_a,
    input logic          en_a_n,
    input logic          we_a_n,
    input logic [1:0]    shape_a,
    input logic          pipe_a,
    input logic          wshow_a,
    input logic [11:0]   addr_a,
    input logic [8:0]    din_a,
    input logic [8:0]    dout_a,
    input logic          clk_b,
    input logic          en_b_n,
    input logic          we_b_n,
    input logic [1:0]    shape_b,
    input logic          pipe_b,
    input logic          wshow_b,
    input logic [11:0]   addr_b,
    input logic [8:0]    din_b,
    input logic [8:0]    dout_b,
    input logic          rst_n
);
    logic live_a, live_b, rst_seen_a, rst_seen_b;

    // Track the reset level sampled at the previous edge of each clock.
    always_ff @(posedge clk_a) begin
        live_a     <= 1'b1;
        rst_seen_a <= rst_n;
    end
    always_ff @(posedge clk_b) begin
        live_b     <= 1'b1;
        rst_seen_b <= rst_n;
    end

    // R8: an edge that saw reset low leaves the output at zero.
    always @(posedge clk_a) begin
        if (live_a && !rst_seen_a)
            a_r8_out_zero_a: assert (dout_a == 9'd0) else $error("R8 port A output not cleared");
    end
    always @(posedge clk_b) begin
        if (live_b && !rst_seen_b)
            a_r8_out_zero_b: assert (dout_b == 9'd0) else $error("R8 port B output not cleared");
    end

    // R3: a disabled port keeps its output.
    a_r3_hold_a: assert property (@(posedge clk_a) disable iff (!rst_n)
        en_a_n |=> ($stable(dout_a) || !$stable(pipe_a)))
        else $error("R3 port A output moved while disabled");
    a_r3_hold_b: assert property (@(posedge clk_b) disable iff (!rst_n)
        en_b_n |=> ($stable(dout_b) || !$stable(pipe_b)))
        else $error("R3 port B output moved while disabled");

    // R6: a write with write-show low leaves the unpipelined output alone.
    a_r6_keep_on_write_a: assert property (@(posedge clk_a) disable iff (!rst_n)
        (!en_a_n && !we_a_n && !wshow_a && !pipe_a) |=> ($stable(dout_a) || pipe_a))
        else $error("R6 port A output changed on a held write");

    // R7: a full-width write with write-show high appears at the output.
    a_r7_show_write_a: assert property (@(posedge clk_a) disable iff (!rst_n)
        (!en_a_n && !we_a_n && wshow_a && !pipe_a && shape_a == 2'b11)
        |=> (pipe_a || dout_a == $past(din_a)))
        else $error("R7 port A output does not show written data");

    // R12: bits above the shape width stay zero.
    a_r12_unused_zero_a: assert property (@(posedge clk_a) disable iff (!rst_n)
        (dout_a & ~shp_low_mask(shape_a)) == 9'd0)
        else $error("R12 port A unused output bits set");
    a_r12_unused_zero_b: assert property (@(posedge clk_b) disable iff (!rst_n)
        (dout_b & ~shp_low_mask(shape_b)) == 9'd0)
        else $error("R12 port B unused output bits set");
endmodule

bind shape_dpram shape_dpram_chk u_chk (.*);

// File: tb/shape_dpram_tb.sv
`timescale 1ns/1ps
// Bench: directed scenarios, one task each, for shape_dpram.
module shape_dpram_tb;
    logic        clk_a = 1'b0;
    logic        clk_b_man = 1'b0;
    logic        b_common = 1'b1;
    logic        clk_b;
    logic        rst_n = 1'b0;
    logic        en_a_n = 1'b1, we_a_n = 1'b1, pipe_a = 1'b0, wshow_a = 1'b0;
    logic        en_b_n = 1'b1, we_b_n = 1'b1, pipe_b = 1'b0, wshow_b = 1'b0;
    logic [1:0]  shape_a = 2'b11, shape_b = 2'b11;
    logic [11:0] addr_a = '0, addr_b = '0;
    logic [8:0]  din_a = '0, din_b = '0;
    logic [8:0]  dout_a, dout_b;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2 clk_a = ~clk_a;
    assign clk_b = b_common ? clk_a : clk_b_man;

    shape_dpram u_dut (
        .clk_a(clk_a), .en_a_n(en_a_n), .we_a_n(we_a_n), .shape_a(shape_a),
        .pipe_a(pipe_a), .wshow_a(wshow_a), .addr_a(addr_a), .din_a(din_a),
        .dout_a(dout_a),
        .clk_b(clk_b), .en_b_n(en_b_n), .we_b_n(we_b_n), .shape_b(shape_b),
        .pipe_b(pipe_b), .wshow_b(wshow_b), .addr_b(addr_b), .din_b(din_b),
        .dout_b(dout_b),
        .rst_n(rst_n)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk_a);
    endtask

    task automatic set_a(input logic en, input logic wr, input logic [11:0] ad, input logic [8:0] d);
        en_a_n = !en; we_a_n = !wr; addr_a = ad; din_a = d;
    endtask

    task automatic set_b(input logic en, input logic wr, input logic [11:0] ad, input logic [8:0] d);
        en_b_n = !en; we_b_n = !wr; addr_b = ad; din_b = d;
    endtask

    task automatic do_reset(input logic [1:0] sa, input logic [1:0] sb);
        set_a(0, 0, 0, 0); set_b(0, 0, 0, 0);
        rst_n = 1'b0; shape_a = sa; shape_b = sb;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic wr_a(input logic [11:0] ad, input logic [8:0] d);
        set_a(1, 1, ad, d); step(); set_a(0, 0, 0, 0);
    endtask

    task automatic wr_b(input logic [11:0] ad, input logic [8:0] d);
        set_b(1, 1, ad, d); step(); set_b(0, 0, 0, 0);
    endtask

    task automatic rd_chk_a(input logic [11:0] ad, input logic [8:0] exp, input string req);
        set_a(1, 0, ad, 0); step(); set_a(0, 0, 0, 0);
        check(req, dout_a, exp);
    endtask

    task automatic rd_chk_b(input logic [11:0] ad, input logic [8:0] exp, input string req);
        set_b(1, 0, ad, 0); step(); set_b(0, 0, 0, 0);
        check(req, dout_b, exp);
    endtask

    // R8: outputs start at zero after reset.
    task automatic t_reset_state();
        do_reset(2'b11, 2'b11);
        check("R8 reset A", dout_a, 9'h000);
        check("R8 reset B", dout_b, 9'h000);
    endtask

    // R1, R4: x9 writes through both ports, unpipelined reads including top row.
    task automatic t_x9_basic();
        wr_a(12'd0, 9'h1A5);
        wr_a(12'd511, 9'h0C3);
        wr_b(12'd100, 9'h13C);
        rd_chk_a(12'd0, 9'h1A5, "R4 read A");
        rd_chk_b(12'd511, 9'h0C3, "R1 last x9 word");
        rd_chk_a(12'd100, 9'h13C, "R1 cross-port");
    endtask

    // R3: disabled port holds output and does not write.
    task automatic t_enable();
        rd_chk_a(12'd0, 9'h1A5, "R3 setup");
        set_a(0, 1, 12'd511, 9'h000); step();
        check("R3 hold while disabled", dout_a, 9'h1A5);
        rd_chk_a(12'd511, 9'h0C3, "R3 no write while disabled");
    endtask

    // R5: pipelined reads arrive one edge later and stream.
    task automatic t_pipe();
        pipe_a = 1'b1;
        set_a(1, 0, 12'd100, 0); step(); step();
        check("R5 settle", dout_a, 9'h13C);
        set_a(1, 0, 12'd0, 0); step();
        check("R5 not yet", dout_a, 9'h13C);
        set_a(1, 0, 12'd511, 0); step();
        check("R5 one later", dout_a, 9'h1A5);
        step();
        check("R5 stream", dout_a, 9'h0C3);
        set_a(0, 0, 0, 0); pipe_a = 1'b0;
    endtask

    // R6, R7: output behaviour during writes.
    task automatic t_wmode();
        rd_chk_a(12'd0, 9'h1A5, "R6 setup");
        wshow_a = 1'b0; wr_a(12'd20, 9'h0AA);
        check("R6 keep last read", dout_a, 9'h1A5);
        rd_chk_a(12'd20, 9'h0AA, "R6 write landed");
        wshow_a = 1'b1; wr_a(12'd20, 9'h155);
        check("R7 show written", dout_a, 9'h155);
        wshow_a = 1'b0;
    endtask

    // R8: reset blocks writes and keeps contents.
    task automatic t_reset_contents();
        rd_chk_a(12'd20, 9'h155, "R8 setup");
        rst_n = 1'b0; set_a(1, 1, 12'd20, 9'h000); step();
        check("R8 cleared under reset", dout_a, 9'h000);
        step(); rst_n = 1'b1; set_a(0, 0, 0, 0);
        rd_chk_a(12'd20, 9'h155, "R8 contents kept");
    endtask

    // R10, R11: same-cycle interactions on a common clock.
    task automatic t_collision();
        set_a(1, 1, 12'd7, 9'h0F0); set_b(1, 1, 12'd7, 9'h10F); step();
        set_a(0, 0, 0, 0); set_b(0, 0, 0, 0);
        rd_chk_a(12'd7, 9'h0F0, "R10 A wins via A");
        rd_chk_b(12'd7, 9'h0F0, "R10 A wins via B");
        wr_a(12'd8, 9'h011);
        set_a(1, 1, 12'd8, 9'h0EE); set_b(1, 0, 12'd8, 0); step();
        set_a(0, 0, 0, 0); set_b(0, 0, 0, 0);
        check("R11 B reads old", dout_b, 9'h011);
        rd_chk_b(12'd8, 9'h0EE, "R11 new after");
        set_b(1, 1, 12'd8, 9'h1DD); set_a(1, 0, 12'd8, 0); step();
        set_a(0, 0, 0, 0); set_b(0, 0, 0, 0);
        check("R11 A reads old", dout_a, 9'h0EE);
        rd_chk_a(12'd8, 9'h1DD, "R11 new after A");
    endtask

    // R2, R9, R12, R7: mixed shapes on shared rows.
    task automatic t_shapes();
        wr_a(12'd0, 9'h169);
        wr_a(12'd1, 9'h101);
        do_reset(2'b11, 2'b00);
        rd_chk_b(12'd0, 9'h001, "R9 x1 bit0");
        rd_chk_b(12'd1, 9'h000, "R9 x1 bit1");
        rd_chk_b(12'd3, 9'h001, "R12 x1 bit3");
        rd_chk_b(12'd8, 9'h001, "R9 x1 next row");
        do_reset(2'b11, 2'b01);
        rd_chk_b(12'd1, 9'h002, "R9 x2 word1");
        rd_chk_b(12'h801, 9'h002, "R2 x2 bit11 ignored");
        rd_chk_b(12'd3, 9'h001, "R9 x2 word3");
        do_reset(2'b11, 2'b10);
        rd_chk_b(12'hC01, 9'h006, "R2 x4 bits11-10 ignored");
        rd_chk_b(12'd0, 9'h009, "R9 x4 word0");
        wr_b(12'd3, 9'h1FF);
        rd_chk_a(12'd1, 9'h1F1, "R12 narrow write masked");
        wshow_b = 1'b1; wr_b(12'd3, 9'h1F5); wshow_b = 1'b0;
        check("R12 show write cut to width", dout_b, 9'h005);
        rd_chk_a(12'd1, 9'h151, "R7 narrow write stored");
        wr_b(12'hC02, 9'h00A);
        rd_chk_a(12'd1, 9'h15A, "R2 write with high bits ignored");
    endtask

    // R13: port B acts only on its own clock.
    task automatic t_indep_clock();
        do_reset(2'b11, 2'b11);
        wr_a(12'd9, 9'h045);
        b_common = 1'b0;
        set_b(1, 1, 12'd9, 9'h123);
        rd_chk_a(12'd9, 9'h045, "R13 no B edge yet");
        rd_chk_a(12'd9, 9'h045, "R13 still pending");
        #0.5 clk_b_man = 1'b1;
        #0.5 clk_b_man = 1'b0;
        set_b(0, 0, 0, 0);
        rd_chk_a(12'd9, 9'h123, "R13 after B edge");
        b_common = 1'b1;
    endtask

    initial begin
        step();
        t_reset_state();
        t_x9_basic();
        t_enable();
        t_pipe();
        t_wmode();
        t_reset_contents();
        t_collision();
        t_shapes();
        t_indep_clock();
        step();
        done = 1'b1;
        summary();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
        end
    end
endmodule